// File: doc/BRIEF.md
# Hybrid Circuit/Packet Mesh Router

A five-port router for a two-dimensional on-chip mesh. It has a local processor port and four neighbour ports. All links run in one direction only. Every output port works in one of two modes, and the mode can change while the router runs. In circuit mode, a per-output configuration entry names one input. Flits from that input go straight to the output register, with no buffering, routing or arbitration, so a hop costs one cycle. In packet mode, flits are captured, queued in a per-input FIFO and routed X-then-Y on the destination coordinates. Each output runs round-robin arbitration among the inputs whose head flits want it, and a hop costs three register stages.

Circuits are set up and torn down through a sideband command port. The router answers every command one cycle later. The number of live circuits is limited by a parameter. When a new circuit needs a slot and none is free, the router drops the circuit that was used least recently, where "used" means it was set up or it carried a flit. A packet bound for an output held by a circuit stays in its input FIFO until that circuit is released. It never disturbs circuit traffic.

Top module: `hybrid_mesh_router`

## Requirements
- R1: After reset, no output is valid, no output is in circuit mode, `cfg_ack` is low and every `in_ready` bit is high.
- R2: While output o holds a circuit from input s, a flit presented on input s at a clock edge appears on output o after that same edge, unchanged. It does not also enter the packet path.
- R3: Port numbering is 0 local, 1 north (+y), 2 south (-y), 3 east (+x), 4 west (-x). A flit carries destination x in bits [15:12], destination y in [11:8] and payload in [7:0]. A packet goes east or west until its x matches `node_x`, then north or south until its y matches `node_y`, then to local.
- R4: A packet arriving at an idle router, on an output not held by a circuit, becomes valid at its output two cycles later than a circuit flit would (three register stages).
- R5: Each output grants one buffered packet per cycle. When several inputs contend, it searches from the input after the one it granted last, in ascending index order with wrap-around.
- R6: A packet routed to an output held by a circuit waits in its FIFO. It leaves, in order, once the circuit is torn down. A held output never shows a packet.
- R7: `cfg_ack` is high exactly in the cycle after each command (`cfg_valid`). The circuit table, seen on `out_circuit`, shows the command's effect from that same cycle.
- R8: At most CIRC_MAX outputs hold circuits. A setup on a free output when the table is full first drops the least recently used circuit.
- R9: A setup on an output that already holds a circuit rebinds its source and drops no other circuit.
- R10: A teardown takes effect only if it names the output's current source. Any other teardown leaves the table unchanged.
- R11: A flit arriving in the same cycle as a setup for its input uses the table as it was before the command, so it takes the packet path.
- R12: `in_ready[i]` is low when the FIFO occupancy plus the flit in the capture stage of input i reaches FIFO_DEPTH. A packet-path flit offered while it is low is dropped, and the FIFO never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_x | input | COORD_W | This router's x coordinate |
| node_y | input | COORD_W | This router's y coordinate |
| in_valid | input | 5 | Per-input flit valid |
| in_flit | input | 5*FLIT_W | Per-input flits, port p at [p*FLIT_W +: FLIT_W] |
| in_ready | output | 5 | Per-input packet-path space available |
| out_valid | output | 5 | Per-output flit valid |
| out_flit | output | 5*FLIT_W | Per-output flits |
| out_circuit | output | 5 | Output currently held by a circuit |
| cfg_valid | input | 1 | Circuit command valid |
| cfg_setup | input | 1 | 1 = set up, 0 = tear down |
| cfg_src | input | 3 | Input port of the circuit |
| cfg_dst | input | 3 | Output port of the circuit |
| cfg_ack | output | 1 | Command acknowledge, one cycle after `cfg_valid` |

## Verification
Two functions can land in the same clock cycle. One is a setup command together with a flit on the input that command names. The other is an eviction together with the recency update from circuit traffic. The first case is forced by driving `cfg_valid` and `in_valid` on one port in a single cycle. The flit must show up three stages later on its packet route and not on the new circuit. The second case is forced by sending a flit on one circuit just before a third setup. The check is which output bit clears in `out_circuit`, which shows whether the traffic touch counted before the victim was chosen.

// File: rtl/hybrid_mesh_router.sv
module hybrid_mesh_router #(
  parameter int COORD_W    = 4,
  parameter int PAY_W      = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int CIRC_MAX   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [COORD_W-1:0]        node_x,
  input  logic [COORD_W-1:0]        node_y,
  input  logic [4:0]                in_valid,
  input  logic [5*(2*COORD_W+PAY_W)-1:0] in_flit,
  output logic [4:0]                in_ready,
  output logic [4:0]                out_valid,
  output logic [5*(2*COORD_W+PAY_W)-1:0] out_flit,
  output logic [4:0]                out_circuit,
  input  logic                      cfg_valid,
  input  logic                      cfg_setup,
  input  logic [2:0]                cfg_src,
  input  logic [2:0]                cfg_dst,
  output logic                      cfg_ack
);
  localparam int NP     = 5;
  localparam int PW     = 3;
  localparam int FLIT_W = 2*COORD_W + PAY_W;
  localparam int AW     = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW     = $clog2(FIFO_DEPTH + 1);

  logic [NP-1:0]     circ_act;
  logic [PW-1:0]     circ_src [NP];
  logic [NP-1:0]     recent   [NP];
  logic [NP-1:0]     rec_n    [NP];
  logic [NP-1:0]     cap_v;
  logic [FLIT_W-1:0] cap_f    [NP];
  logic [FLIT_W-1:0] mem      [NP][FIFO_DEPTH];
  logic [AW-1:0]     wp       [NP];
  logic [AW-1:0]     rp       [NP];
  logic [CW-1:0]     cnt      [NP];
  logic [PW-1:0]     rr       [NP];
  logic [NP-1:0]     req      [NP];
  logic [NP-1:0]     gnt      [NP];
  logic [PW-1:0]     gsel     [NP];
  logic [NP-1:0]     pop;
  logic [NP-1:0]     in_circ;
  logic [FLIT_W-1:0] out_r    [NP];
  logic [PW-1:0]     lru;
  logic              set_ok, tear_ok, full;
  logic [NP*PW-1:0]  src_flat;
  logic [NP*CW-1:0]  fill_flat;

  function automatic logic [PW-1:0] route_of(input logic [FLIT_W-1:0] f,
                                             input logic [COORD_W-1:0] x,
                                             input logic [COORD_W-1:0] y);
    logic [COORD_W-1:0] dx, dy;
    dx = f[FLIT_W-1 -: COORD_W];
    dy = f[FLIT_W-COORD_W-1 -: COORD_W];
    if (dx > x)      return PW'(3);
    else if (dx < x) return PW'(4);
    else if (dy > y) return PW'(1);
    else if (dy < y) return PW'(2);
    else             return PW'(0);
  endfunction

  assign set_ok  = cfg_valid && cfg_setup  && (cfg_src < PW'(NP)) && (cfg_dst < PW'(NP));
  assign tear_ok = cfg_valid && !cfg_setup && (cfg_dst < PW'(NP)) &&
                   circ_act[cfg_dst] && (circ_src[cfg_dst] == cfg_src);
  assign full    = ($countones(circ_act) >= CIRC_MAX);
  assign out_circuit = circ_act;

  genvar g;
  generate
    for (g = 0; g < NP; g++) begin : g_port
      assign in_ready[g] = (int'(cnt[g]) + int'(cap_v[g])) < FIFO_DEPTH;
      assign out_flit[g*FLIT_W +: FLIT_W] = out_r[g];
      assign src_flat[g*PW +: PW]   = circ_src[g];
      assign fill_flat[g*CW +: CW]  = cnt[g];
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      in_circ[i] = 1'b0;
      for (int o = 0; o < NP; o++)
        if (circ_act[o] && circ_src[o] == PW'(i)) in_circ[i] = 1'b1;
    end
  end

  always_comb begin
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        req[o][i] = (cnt[i] != '0) && !circ_act[o] &&
                    (route_of(mem[i][rp[i]], node_x, node_y) == PW'(o));
  end

  always_comb begin
    for (int o = 0; o < NP; o++) begin
      logic found;
      found   = 1'b0;
      gnt[o]  = '0;
      gsel[o] = '0;
      for (int k = 1; k <= NP; k++) begin
        int idx;
        idx = (int'(rr[o]) + k) % NP;
        if (!found && req[o][idx]) begin
          found       = 1'b1;
          gnt[o][idx] = 1'b1;
          gsel[o]     = PW'(idx);
        end
      end
    end
    for (int i = 0; i < NP; i++) begin
      pop[i] = 1'b0;
      for (int o = 0; o < NP; o++) pop[i] = pop[i] | gnt[o][i];
    end
  end

  always_comb begin
    for (int a = 0; a < NP; a++) rec_n[a] = recent[a];
    for (int o = 0; o < NP; o++) begin
      if (circ_act[o] && in_valid[circ_src[o]]) begin
        for (int j = 0; j < NP; j++) rec_n[j][o] = 1'b0;
        rec_n[o]    = '1;
        rec_n[o][o] = 1'b0;
      end
    end
    if (set_ok) begin
      for (int j = 0; j < NP; j++) rec_n[j][cfg_dst] = 1'b0;
      rec_n[cfg_dst]          = '1;
      rec_n[cfg_dst][cfg_dst] = 1'b0;
    end
  end

  always_comb begin
    logic hit;
    hit = 1'b0;
    lru = '0;
    for (int o = 0; o < NP; o++) begin
      logic oldest;
      oldest = circ_act[o];
      for (int j = 0; j < NP; j++)
        if (j != o && circ_act[j] && !recent[j][o]) oldest = 1'b0;
      if (oldest && !hit) begin
        hit = 1'b1;
        lru = PW'(o);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      circ_act <= '0;
      cfg_ack  <= 1'b0;
      for (int o = 0; o < NP; o++) begin
        circ_src[o] <= '0;
        recent[o]   <= '0;
      end
    end else begin
      cfg_ack <= cfg_valid;
      for (int o = 0; o < NP; o++) recent[o] <= rec_n[o];
      if (set_ok) begin
        circ_src[cfg_dst] <= cfg_src;
        circ_act[cfg_dst] <= 1'b1;
        if (!circ_act[cfg_dst] && full) circ_act[lru] <= 1'b0;
      end else if (tear_ok) begin
        circ_act[cfg_dst] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_v     <= '0;
      out_valid <= '0;
      for (int i = 0; i < NP; i++) begin
        wp[i]    <= '0;
        rp[i]    <= '0;
        cnt[i]   <= '0;
        rr[i]    <= '0;
        cap_f[i] <= '0;
        out_r[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NP; i++) begin
        cap_v[i] <= in_valid[i] && in_ready[i] && !in_circ[i];
        cap_f[i] <= in_flit[i*FLIT_W +: FLIT_W];
        if (cap_v[i]) wp[i] <= (int'(wp[i]) == FIFO_DEPTH-1) ? '0 : wp[i] + 1'b1;
        if (pop[i])   rp[i] <= (int'(rp[i]) == FIFO_DEPTH-1) ? '0 : rp[i] + 1'b1;
        cnt[i] <= cnt[i] + CW'(cap_v[i]) - CW'(pop[i]);
      end
      for (int o = 0; o < NP; o++) begin
        if (circ_act[o]) begin
          out_valid[o] <= in_valid[circ_src[o]];
          out_r[o]     <= in_flit[circ_src[o]*FLIT_W +: FLIT_W];
        end else begin
          out_valid[o] <= |gnt[o];
          out_r[o]     <= mem[gsel[o]][rp[gsel[o]]];
        end
        if (|gnt[o]) rr[o] <= gsel[o];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NP; i++)
      if (cap_v[i]) mem[i][wp[i]] <= cap_f[i];
  end
endmodule

// File: rtl/hybrid_mesh_router_chk.sv
module hybrid_mesh_router_chk #(
  parameter int NP       = 5,
  parameter int PW       = 3,
  parameter int CW       = 3,
  parameter int DEPTH    = 4,
  parameter int CIRC_MAX = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_valid,
  input logic              cfg_ack,
  input logic [NP-1:0]     in_valid,
  input logic [NP-1:0]     out_valid,
  input logic [NP-1:0]     circ_act,
  input logic [NP*PW-1:0]  src_flat,
  input logic [NP*CW-1:0]  fill_flat,
  input logic [NP-1:0]     cap_v
);
  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n) cfg_valid |=> cfg_ack); // R7
  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) cfg_ack |-> $past(cfg_valid)); // R7
  AST_CIRC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) $countones(circ_act) <= CIRC_MAX); // R8

  genvar g;
  generate
    for (g = 0; g < NP; g++) begin : g_chk
      AST_CIRC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        circ_act[g] && in_valid[src_flat[g*PW +: PW]] |=> out_valid[g]); // R2
      AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        circ_act[g] && !in_valid[src_flat[g*PW +: PW]] |=> !out_valid[g]); // R6
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fill_flat[g*CW +: CW]) + int'(cap_v[g])) <= DEPTH); // R12
    end
  endgenerate
endmodule

bind hybrid_mesh_router hybrid_mesh_router_chk #(
  .NP(5), .PW(3), .CW($clog2(FIFO_DEPTH + 1)), .DEPTH(FIFO_DEPTH), .CIRC_MAX(CIRC_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ack(cfg_ack),
  .in_valid(in_valid), .out_valid(out_valid), .circ_act(circ_act),
  .src_flat(src_flat), .fill_flat(fill_flat), .cap_v(cap_v)
);

// File: tb/tb_hybrid_mesh_router.sv
module tb_hybrid_mesh_router;
  localparam int FW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  node_x = 4'd5, node_y = 4'd5;
  logic [4:0]  in_valid = '0;
  logic [5*FW-1:0] in_flit = '0;
  logic [4:0]  in_ready, out_valid, out_circuit;
  logic [5*FW-1:0] out_flit;
  logic        cfg_valid = 1'b0, cfg_setup = 1'b0, cfg_ack;
  logic [2:0]  cfg_src = '0, cfg_dst = '0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  hybrid_mesh_router dut (
    .clk(clk), .rst_n(rst_n), .node_x(node_x), .node_y(node_y),
    .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
    .out_valid(out_valid), .out_flit(out_flit), .out_circuit(out_circuit),
    .cfg_valid(cfg_valid), .cfg_setup(cfg_setup), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_ack(cfg_ack)
  );

  always #10 clk = ~clk;

  function automatic logic [FW-1:0] mk(input int dx, input int dy, input int pay);
    return {4'(dx), 4'(dy), 8'(pay)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic put(input int p, input logic [FW-1:0] f);
    in_valid[p] = 1'b1;
    in_flit[p*FW +: FW] = f;
  endtask

  task automatic clr();
    in_valid = '0; in_flit = '0; cfg_valid = 1'b0;
  endtask

  function automatic logic [FW-1:0] outf(input int p);
    return out_flit[p*FW +: FW];
  endfunction

  task automatic cmd(input bit setup, input int s, input int d);
    cfg_valid = 1'b1; cfg_setup = setup; cfg_src = 3'(s); cfg_dst = 3'(d);
    @(negedge clk); clr();
    chk("R7 ack after command", 32'(cfg_ack), 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 out_valid", 32'(out_valid), 32'h0);
    chk("R1 out_circuit", 32'(out_circuit), 32'h0);
    chk("R1 in_ready", 32'(in_ready), 32'h1f);
    chk("R1 cfg_ack", 32'(cfg_ack), 32'h0);
  endtask

  task automatic t_route(input int s, input int dx, input int dy, input int ep, input int pay);
    logic [FW-1:0] f;
    f = mk(dx, dy, pay);
    put(s, f);
    @(negedge clk); clr();
    chk("R4 not early 1", 32'(out_valid), 32'h0);
    @(negedge clk);
    chk("R4 not early 2", 32'(out_valid), 32'h0);
    @(negedge clk);
    chk("R3 R4 route port", 32'(out_valid), 32'(1 << ep));
    chk("R3 flit", 32'(outf(ep)), 32'(f));
    @(negedge clk);
  endtask

  task automatic t_rr();
    put(1, mk(5,5,8'h11)); put(2, mk(5,5,8'h12)); put(3, mk(5,5,8'h13));
    @(negedge clk); clr();
    @(negedge clk);
    @(negedge clk); chk("R5 first grant in1", 32'(outf(0)), 32'(mk(5,5,8'h11)));
    @(negedge clk); chk("R5 second grant in2", 32'(outf(0)), 32'(mk(5,5,8'h12)));
    @(negedge clk); chk("R5 third grant in3", 32'(outf(0)), 32'(mk(5,5,8'h13)));
    @(negedge clk); chk("R5 drained", 32'(out_valid), 32'h0);
    put(1, mk(5,5,8'h21)); put(2, mk(5,5,8'h22)); put(4, mk(5,5,8'h24));
    @(negedge clk); clr();
    @(negedge clk);
    @(negedge clk); chk("R5 rotate in4 first", 32'(outf(0)), 32'(mk(5,5,8'h24)));
    @(negedge clk); chk("R5 rotate in1 next", 32'(outf(0)), 32'(mk(5,5,8'h21)));
    @(negedge clk); chk("R5 rotate in2 last", 32'(outf(0)), 32'(mk(5,5,8'h22)));
    @(negedge clk);
  endtask

  task automatic t_circuit();
    cmd(1, 4, 3);
    chk("R7 table visible", 32'(out_circuit), 32'h08);
    put(4, mk(5,5,8'hA1));
    @(negedge clk); clr();
    chk("R7 ack single", 32'(cfg_ack), 32'd0);
    chk("R2 circuit one cycle", 32'(out_valid), 32'h08);
    chk("R2 circuit flit", 32'(outf(3)), 32'(mk(5,5,8'hA1)));
    put(0, mk(9,5,8'hB2));
    @(negedge clk); clr();
    @(negedge clk);
    chk("R2 no packet copy", 32'(out_valid), 32'h0);
    @(negedge clk);
    chk("R6 held packet waits", 32'(out_valid), 32'h0);
    cmd(0, 0, 3);
    chk("R10 wrong teardown ignored", 32'(out_circuit), 32'h08);
    @(negedge clk);
    chk("R10 still held", 32'(out_valid), 32'h0);
    cmd(1, 1, 3);
    chk("R9 rebind keeps one circuit", 32'(out_circuit), 32'h08);
    put(1, mk(5,5,8'hC3));
    @(negedge clk); clr();
    chk("R9 new source drives", 32'(outf(3)), 32'(mk(5,5,8'hC3)));
    chk("R9 valid only east", 32'(out_valid), 32'h08);
    cmd(0, 1, 3);
    chk("R6 teardown frees output", 32'(out_circuit), 32'h0);
    @(negedge clk);
    chk("R6 released packet valid", 32'(out_valid), 32'h08);
    chk("R6 released packet flit", 32'(outf(3)), 32'(mk(9,5,8'hB2)));
    @(negedge clk);
  endtask

  task automatic t_lru();
    cmd(1, 0, 1);
    cmd(1, 2, 3);
    chk("R8 two circuits", 32'(out_circuit), 32'h0a);
    put(0, mk(5,5,8'hD4));
    @(negedge clk); clr();
    chk("R2 north circuit", 32'(outf(1)), 32'(mk(5,5,8'hD4)));
    cmd(1, 1, 4);
    chk("R8 unused circuit evicted", 32'(out_circuit), 32'h12);
    cmd(1, 3, 0);
    chk("R8 older circuit evicted", 32'(out_circuit), 32'h11);
    cmd(0, 1, 4);
    cmd(0, 3, 0);
    chk("R8 all torn down", 32'(out_circuit), 32'h0);
    @(negedge clk);
  endtask

  task automatic t_same_cycle();
    cfg_valid = 1'b1; cfg_setup = 1'b1; cfg_src = 3'd2; cfg_dst = 3'd3;
    put(2, mk(5,5,8'hE5));
    @(negedge clk); clr();
    chk("R11 circuit set", 32'(out_circuit), 32'h08);
    chk("R11 not forwarded", 32'(out_valid), 32'h0);
    @(negedge clk);
    @(negedge clk);
    chk("R11 packet path local", 32'(out_valid), 32'h01);
    chk("R11 packet flit", 32'(outf(0)), 32'(mk(5,5,8'hE5)));
    @(negedge clk);
  endtask

  task automatic t_ready();
    for (int k = 1; k <= 4; k++) begin
      chk("R12 ready while space", 32'(in_ready[0]), 32'd1);
      put(0, mk(9,5,k));
      @(negedge clk); clr();
    end
    chk("R12 ready low when full", 32'(in_ready[0]), 32'd0);
    put(0, mk(9,5,8'h55));
    @(negedge clk); clr();
    chk("R6 held while full", 32'(out_valid), 32'h0);
    cmd(0, 2, 3);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk("R12 drain valid", 32'(out_valid), 32'h08);
      chk("R12 drain order", 32'(outf(3)), 32'(mk(9,5,k)));
    end
    @(negedge clk);
    chk("R12 extra flit dropped", 32'(out_valid), 32'h0);
    chk("R12 ready restored", 32'(in_ready[0]), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_route(0, 7, 2, 3, 8'h01);
    t_route(1, 2, 9, 4, 8'h02);
    t_route(2, 5, 9, 1, 8'h03);
    t_route(3, 5, 1, 2, 8'h04);
    t_route(4, 5, 5, 0, 8'h05);
    t_rr();
    t_circuit();
    t_lru();
    t_same_cycle();
    t_ready();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule